// File: doc/BRIEF.md
# On-Demand Operand Read Stage

This block is the operand-read stage of a short in-order pipeline. The stages run in this order: fetch, decode, operand read, execute 1, execute 2, write-back. Decode hands over up to two source register indices and one destination index, each with a valid bit. For each source the stage first checks the forwarding network. It enables a register-file read only when no forwarding path supplies the value, which cuts the number of register-file accesses.

Forwarding is partial. The only path carries the result sitting in the execute 2 stage, and it reaches only the second source port (port B). Port A always takes its value from the register file, which writes through during write-back. If a needed value is not reachable yet, the stage holds the instruction, tells decode to wait, and sends a bubble into execute 1. Two counters record the enabled register-file reads and the operands served by the forwarding path. The register file sits inside the block, and its single write port is driven by the write-back stage.

Top module: `ondemand_opread`

## Requirements
- R1: An instruction in the operand-read stage that is not held appears on the execute-1 outputs at the next clock edge. The outputs carry its destination fields and the correct architectural value of each source operand in program order.
- R2: A register-file read port is enabled only when its source is served by neither the forwarding path nor the zero rule, and only in a cycle in which the instruction leaves the stage.
- R3: The forwarding path carries only the execute-2 result, and it reaches only port B. The value is taken when the execute-2 destination equals the port-B source.
- R4: Port A is never served by forwarding. If port A's source matches the execute-2 destination, the stage holds until the producer reaches write-back.
- R5: A consumer directly behind its producer is held. It waits 1 cycle when the dependence is on port B and 2 cycles when the dependence is on port A.
- R6: A consumer one unrelated instruction behind its producer on port B takes the value from the forwarding path. It does not hold and does not read the register file for that port.
- R7: A register-file read of the register being written back in the same cycle returns the new value.
- R8: When execute 1 and execute 2 both hold the needed destination, the younger producer (execute 1) decides. The consumer ends up with the younger producer's result.
- R9: A source that is invalid or names register 0 yields operand 0. It never reads the file, never forwards and never holds. A producer whose destination valid bit is clear never matches.
- R10: While held, dec_hold is 1, the stage keeps its instruction, and x1_vld is 0 at the next edge.
- R11: rf_rd_cnt rises by the number of read enables asserted in the previous cycle. byp_cnt rises by the number of forwarded operands of the instruction that left the stage.
- R12: After reset, x1_vld, dec_hold, both read enables and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dec_vld | input | 1 | Decode offers an instruction |
| dec_sa_vld | input | 1 | Source A used |
| dec_sa | input | AW | Source A index |
| dec_sb_vld | input | 1 | Source B used |
| dec_sb | input | AW | Source B index |
| dec_dst_vld | input | 1 | Destination written |
| dec_dst | input | AW | Destination index |
| dec_hold | output | 1 | Operand-read stage held; decode keeps its instruction |
| x2_vld | input | 1 | Execute-2 stage holds a result with a destination |
| x2_dst | input | AW | Execute-2 destination |
| x2_res | input | XLEN | Execute-2 result |
| wb_vld | input | 1 | Write-back write enable |
| wb_dst | input | AW | Write-back register index |
| wb_data | input | XLEN | Write-back data |
| rf_rd_en_a | output | 1 | Register-file read enable, port A |
| rf_rd_en_b | output | 1 | Register-file read enable, port B |
| x1_vld | output | 1 | Execute-1 stage valid |
| x1_opa | output | XLEN | Operand A to execute 1 |
| x1_opb | output | XLEN | Operand B to execute 1 |
| x1_dst_vld | output | 1 | Destination valid to execute 1 |
| x1_dst | output | AW | Destination index to execute 1 |
| rf_rd_cnt | output | CNT_W | Enabled register-file reads |
| byp_cnt | output | CNT_W | Operands served by forwarding |

## Verification
The assertions assume that decode keeps its offered fields unchanged while dec_hold is 1. They also assume that x2_* and wb_* are the registered images of the block's own execute-1 outputs, one and two cycles later. The bench builds execute 2 and write-back exactly that way from x1_*. It drives decode only at falling edges and re-presents the same instruction until dec_hold drops. Register preloads go through the write port only while the pipeline is empty, so they never coincide with a real write-back.

// File: rtl/odr_pkg.sv
package odr_pkg;

   // Where an operand of the instruction in the operand-read stage comes from
   typedef enum logic [1:0] {
      SRC_ZERO = 2'd0,   // unused source or register 0
      SRC_RF   = 2'd1,   // register file (with write-back write-through)
      SRC_BYP  = 2'd2,   // execute-2 forwarding path
      SRC_WAIT = 2'd3    // not reachable yet, hold the stage
   } opsrc_e;

endpackage

// File: rtl/odr_regfile.sv
module odr_regfile #(
   parameter int unsigned XLEN = 32,
   parameter int unsigned NREG = 16,
   localparam int unsigned AW = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            we,
   input  logic [AW-1:0]   wa,
   input  logic [XLEN-1:0] wd,
   input  logic            re_a,
   input  logic [AW-1:0]   ra_a,
   output logic [XLEN-1:0] rd_a,
   input  logic            re_b,
   input  logic [AW-1:0]   ra_b,
   output logic [XLEN-1:0] rd_b
);

   logic [XLEN-1:0] mem [NREG];

   always_ff @(posedge clk) begin
      if (we && wa != '0) mem[wa] <= wd;
   end

   // one read port per source; write-through gives the new value in the write cycle
   function automatic logic [XLEN-1:0] rd_port(input logic re, input logic [AW-1:0] ra);
      logic [XLEN-1:0] v;
      v = '0;
      if (re && ra != '0) begin
         if (we && wa == ra) v = wd;
         else                v = mem[ra];
      end
      return v;
   endfunction

   always_comb rd_a = rd_port(re_a, ra_a);
   always_comb rd_b = rd_port(re_b, ra_b);

endmodule

// File: rtl/odr_src_resolve.sv
module odr_src_resolve
   import odr_pkg::*;
#(
   parameter int unsigned AW        = 4,
   parameter bit          ALLOW_BYP = 1'b0
) (
   input  logic          use_v,
   input  logic [AW-1:0] src,
   input  logic          x1_hit_v,
   input  logic [AW-1:0] x1_dst,
   input  logic          x2_hit_v,
   input  logic [AW-1:0] x2_dst,
   output opsrc_e        sel
);

   logic   live;
   logic   x1_match;
   logic   x2_match;
   opsrc_e x2_sel;

   assign live     = use_v && (src != '0);
   assign x1_match = x1_hit_v && (x1_dst == src);
   assign x2_match = x2_hit_v && (x2_dst == src);

   // a port either owns the execute-2 forwarding path or must wait for write-back
   generate
      if (ALLOW_BYP) begin : g_fwd
         assign x2_sel = SRC_BYP;
      end else begin : g_nofwd
         assign x2_sel = SRC_WAIT;
      end
   endgenerate

   // youngest producer first: execute 1 shadows execute 2
   always_comb begin
      if (!live)         sel = SRC_ZERO;
      else if (x1_match) sel = SRC_WAIT;
      else if (x2_match) sel = x2_sel;
      else               sel = SRC_RF;
   end

endmodule

// File: rtl/odr_usage_ctr.sv
module odr_usage_ctr #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       rd_inc,
   input  logic [1:0]       byp_inc,
   output logic [CNT_W-1:0] rd_cnt,
   output logic [CNT_W-1:0] byp_cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_cnt  <= '0;
         byp_cnt <= '0;
      end else begin
         rd_cnt  <= rd_cnt  + CNT_W'(rd_inc);
         byp_cnt <= byp_cnt + CNT_W'(byp_inc);
      end
   end

endmodule

// File: rtl/ondemand_opread.sv
module ondemand_opread
   import odr_pkg::*;
#(
   parameter int unsigned XLEN         = 32,
   parameter int unsigned NREG         = 16,
   parameter int unsigned CNT_W        = 16,
   parameter bit          PORTB_BYPASS = 1'b1,
   localparam int unsigned AW = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dec_vld,
   input  logic             dec_sa_vld,
   input  logic [AW-1:0]    dec_sa,
   input  logic             dec_sb_vld,
   input  logic [AW-1:0]    dec_sb,
   input  logic             dec_dst_vld,
   input  logic [AW-1:0]    dec_dst,
   output logic             dec_hold,
   input  logic             x2_vld,
   input  logic [AW-1:0]    x2_dst,
   input  logic [XLEN-1:0]  x2_res,
   input  logic             wb_vld,
   input  logic [AW-1:0]    wb_dst,
   input  logic [XLEN-1:0]  wb_data,
   output logic             rf_rd_en_a,
   output logic             rf_rd_en_b,
   output logic             x1_vld,
   output logic [XLEN-1:0]  x1_opa,
   output logic [XLEN-1:0]  x1_opb,
   output logic             x1_dst_vld,
   output logic [AW-1:0]    x1_dst,
   output logic [CNT_W-1:0] rf_rd_cnt,
   output logic [CNT_W-1:0] byp_cnt
);

   // elaboration-time parameter checks
   generate
      if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
         $error("NREG must be a power of two, at least 2");
      end
      if (XLEN < 1) begin : g_bad_xlen
         $error("XLEN must be at least 1");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
   endgenerate

   // operand-read stage register
   logic          or_vld;
   logic          or_sa_v;
   logic [AW-1:0] or_sa;
   logic          or_sb_v;
   logic [AW-1:0] or_sb;
   logic          or_dv;
   logic [AW-1:0] or_dst;

   opsrc_e sel_a;
   opsrc_e sel_b;
   logic   hold;
   logic   adv;
   logic [XLEN-1:0] rf_a;
   logic [XLEN-1:0] rf_b;
   logic [XLEN-1:0] opa_n;
   logic [XLEN-1:0] opb_n;
   logic   x1_hit_v;

   assign x1_hit_v = x1_vld && x1_dst_vld;

   // port A never owns a forwarding path; port B does when the option is set
   odr_src_resolve #(.AW(AW), .ALLOW_BYP(1'b0)) u_res_a (
      .use_v    (or_vld && or_sa_v),
      .src      (or_sa),
      .x1_hit_v (x1_hit_v),
      .x1_dst   (x1_dst),
      .x2_hit_v (x2_vld),
      .x2_dst   (x2_dst),
      .sel      (sel_a)
   );

   odr_src_resolve #(.AW(AW), .ALLOW_BYP(PORTB_BYPASS)) u_res_b (
      .use_v    (or_vld && or_sb_v),
      .src      (or_sb),
      .x1_hit_v (x1_hit_v),
      .x1_dst   (x1_dst),
      .x2_hit_v (x2_vld),
      .x2_dst   (x2_dst),
      .sel      (sel_b)
   );

   assign hold       = or_vld && (sel_a == SRC_WAIT || sel_b == SRC_WAIT);
   assign adv        = or_vld && !hold;
   assign dec_hold   = hold;
   assign rf_rd_en_a = adv && (sel_a == SRC_RF);
   assign rf_rd_en_b = adv && (sel_b == SRC_RF);

   odr_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
      .clk  (clk),
      .we   (wb_vld),
      .wa   (wb_dst),
      .wd   (wb_data),
      .re_a (rf_rd_en_a),
      .ra_a (or_sa),
      .rd_a (rf_a),
      .re_b (rf_rd_en_b),
      .ra_b (or_sb),
      .rd_b (rf_b)
   );

   function automatic logic [XLEN-1:0] pick(input opsrc_e s, input logic [XLEN-1:0] rf_v);
      logic [XLEN-1:0] v;
      case (s)
         SRC_RF:  v = rf_v;
         SRC_BYP: v = x2_res;
         default: v = '0;
      endcase
      return v;
   endfunction

   always_comb opa_n = pick(sel_a, rf_a);
   always_comb opb_n = pick(sel_b, rf_b);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         or_vld  <= 1'b0;
         or_sa_v <= 1'b0;
         or_sa   <= '0;
         or_sb_v <= 1'b0;
         or_sb   <= '0;
         or_dv   <= 1'b0;
         or_dst  <= '0;
      end else if (!hold) begin
         or_vld  <= dec_vld;
         or_sa_v <= dec_sa_vld;
         or_sa   <= dec_sa;
         or_sb_v <= dec_sb_vld;
         or_sb   <= dec_sb;
         or_dv   <= dec_dst_vld;
         or_dst  <= dec_dst;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x1_vld     <= 1'b0;
         x1_opa     <= '0;
         x1_opb     <= '0;
         x1_dst_vld <= 1'b0;
         x1_dst     <= '0;
      end else begin
         x1_vld     <= adv;
         x1_dst_vld <= adv && or_dv;
         if (adv) begin
            x1_opa <= opa_n;
            x1_opb <= opb_n;
            x1_dst <= or_dst;
         end
      end
   end

   odr_usage_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_inc  ({1'b0, rf_rd_en_a} + {1'b0, rf_rd_en_b}),
      .byp_inc ({1'b0, adv && sel_a == SRC_BYP} + {1'b0, adv && sel_b == SRC_BYP}),
      .rd_cnt  (rf_rd_cnt),
      .byp_cnt (byp_cnt)
   );

endmodule

// File: rtl/ondemand_opread_chk.sv
module ondemand_opread_chk #(
   parameter int unsigned AW    = 4,
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dec_hold,
   input logic             x1_vld,
   input logic             rf_rd_en_a,
   input logic             rf_rd_en_b,
   input logic [CNT_W-1:0] rf_rd_cnt,
   input logic [CNT_W-1:0] byp_cnt,
   input logic             or_vld,
   input logic             or_sa_v,
   input logic [AW-1:0]    or_sa,
   input logic             or_sb_v,
   input logic [AW-1:0]    or_sb,
   input logic             x2_vld,
   input logic [AW-1:0]    x2_dst
);

   // R10
   hold_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_hold |=> !x1_vld);

   // R10
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_hold |=> ($stable(or_sa) && $stable(or_sb)));

   // R2
   read_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_rd_en_a || rf_rd_en_b) |-> !dec_hold);

   // R4
   porta_nofwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (or_vld && or_sa_v && or_sa != '0 && x2_vld && x2_dst == or_sa) |-> dec_hold);

   // R9
   zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (or_vld && (!or_sb_v || or_sb == '0)) |-> !rf_rd_en_b);

   // R11
   rd_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> rf_rd_cnt == $past(rf_rd_cnt) + CNT_W'($past(rf_rd_en_a)) + CNT_W'($past(rf_rd_en_b)));

   // R11
   byp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (byp_cnt == $past(byp_cnt) || byp_cnt == $past(byp_cnt) + CNT_W'(1)));

endmodule

bind ondemand_opread ondemand_opread_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dec_hold   (dec_hold),
   .x1_vld     (x1_vld),
   .rf_rd_en_a (rf_rd_en_a),
   .rf_rd_en_b (rf_rd_en_b),
   .rf_rd_cnt  (rf_rd_cnt),
   .byp_cnt    (byp_cnt),
   .or_vld     (or_vld),
   .or_sa_v    (or_sa_v),
   .or_sa      (or_sa),
   .or_sb_v    (or_sb_v),
   .or_sb      (or_sb),
   .x2_vld     (x2_vld),
   .x2_dst     (x2_dst)
);

// File: tb/ondemand_opread_bench.sv
`timescale 1ns/1ps
module ondemand_opread_bench;

   localparam int XLEN  = 32;
   localparam int NREG  = 16;
   localparam int AW    = 4;
   localparam int CNT_W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic            dec_vld = 0, dec_sa_vld = 0, dec_sb_vld = 0, dec_dst_vld = 0;
   logic [AW-1:0]   dec_sa = 0, dec_sb = 0, dec_dst = 0;
   logic            dec_hold;
   logic            x2_q_vld;
   logic [AW-1:0]   x2_q_dst;
   logic [XLEN-1:0] x2_q_res;
   logic            wb_q_vld;
   logic [AW-1:0]   wb_q_dst;
   logic [XLEN-1:0] wb_q_data;
   logic            pk_vld = 0;
   logic [AW-1:0]   pk_dst = 0;
   logic [XLEN-1:0] pk_data = 0;
   logic            wb_vld;
   logic [AW-1:0]   wb_dst;
   logic [XLEN-1:0] wb_data;
   logic            rf_rd_en_a, rf_rd_en_b;
   logic            x1_vld, x1_dst_vld;
   logic [XLEN-1:0] x1_opa, x1_opb;
   logic [AW-1:0]   x1_dst;
   logic [CNT_W-1:0] rf_rd_cnt, byp_cnt;

   assign wb_vld  = pk_vld | wb_q_vld;
   assign wb_dst  = pk_vld ? pk_dst  : wb_q_dst;
   assign wb_data = pk_vld ? pk_data : wb_q_data;

   ondemand_opread #(.XLEN(XLEN), .NREG(NREG), .CNT_W(CNT_W)) u_ondemand_opread (
      .clk(clk), .rst_n(rst_n),
      .dec_vld(dec_vld), .dec_sa_vld(dec_sa_vld), .dec_sa(dec_sa),
      .dec_sb_vld(dec_sb_vld), .dec_sb(dec_sb),
      .dec_dst_vld(dec_dst_vld), .dec_dst(dec_dst), .dec_hold(dec_hold),
      .x2_vld(x2_q_vld), .x2_dst(x2_q_dst), .x2_res(x2_q_res),
      .wb_vld(wb_vld), .wb_dst(wb_dst), .wb_data(wb_data),
      .rf_rd_en_a(rf_rd_en_a), .rf_rd_en_b(rf_rd_en_b),
      .x1_vld(x1_vld), .x1_opa(x1_opa), .x1_opb(x1_opb),
      .x1_dst_vld(x1_dst_vld), .x1_dst(x1_dst),
      .rf_rd_cnt(rf_rd_cnt), .byp_cnt(byp_cnt)
   );

   // execute 1 adds the operands; execute 2 and write-back are plain registers
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x2_q_vld <= 0; x2_q_dst <= 0; x2_q_res <= 0;
         wb_q_vld <= 0; wb_q_dst <= 0; wb_q_data <= 0;
      end else begin
         x2_q_vld  <= x1_vld && x1_dst_vld;
         x2_q_dst  <= x1_dst;
         x2_q_res  <= x1_opa + x1_opb;
         wb_q_vld  <= x2_q_vld;
         wb_q_dst  <= x2_q_dst;
         wb_q_data <= x2_q_res;
      end
   end

   int n_chk = 0;
   int n_bad = 0;
   int holds = 0;
   int cyc = 0;
   logic [XLEN-1:0] arch [NREG];
   logic [XLEN-1:0] ea [64];
   logic [XLEN-1:0] eb [64];
   string           etag [64];
   int q_wr = 0;
   int q_rd = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // operand monitor (R1) and hold-cycle count
   always @(negedge clk) begin
      cyc++;
      if (rst_n && dec_hold) holds++;
      if (rst_n && x1_vld) begin
         if (q_rd == q_wr) chk(1'b0, "R1 unexpected instruction", 1, 0);
         else begin
            chk(x1_opa == ea[q_rd % 64], {etag[q_rd % 64], " operand A"}, x1_opa, ea[q_rd % 64]);
            chk(x1_opb == eb[q_rd % 64], {etag[q_rd % 64], " operand B"}, x1_opb, eb[q_rd % 64]);
            q_rd++;
         end
      end
   end

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   always @(negedge clk) begin
      if (cyc > 20000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   task automatic poke(input int r, input logic [XLEN-1:0] v);
      @(negedge clk);
      pk_vld = 1; pk_dst = AW'(r); pk_data = v;
      arch[r] = v;
      @(negedge clk);
      pk_vld = 0;
   endtask

   function automatic logic [XLEN-1:0] src_val(input bit v, input int r);
      return (v && r != 0) ? arch[r] : '0;
   endfunction

   task automatic issue(input string tag, input bit av, input int a, input bit bv, input int b,
                        input bit dv, input int d);
      logic [XLEN-1:0] va, vb;
      va = src_val(av, a);
      vb = src_val(bv, b);
      ea[q_wr % 64] = va; eb[q_wr % 64] = vb; etag[q_wr % 64] = tag;
      q_wr++;
      if (dv && d != 0) arch[d] = va + vb;
      @(negedge clk);
      dec_vld = 1; dec_sa_vld = av; dec_sa = AW'(a); dec_sb_vld = bv; dec_sb = AW'(b);
      dec_dst_vld = dv; dec_dst = AW'(d);
      while (dec_hold) @(negedge clk);
      @(posedge clk);
   endtask

   task automatic drain();
      @(negedge clk);
      dec_vld = 0;
      repeat (6) @(negedge clk);
   endtask

   int rd0, by0, h0;
   task automatic open_win();
      @(negedge clk);
      rd0 = rf_rd_cnt; by0 = byp_cnt; h0 = holds;
   endtask

   task automatic close_win(input string req, input int rd, input int by, input int h);
      drain();
      chk(int'(rf_rd_cnt) - rd0 == rd, {req, " register-file reads"}, int'(rf_rd_cnt) - rd0, rd);
      chk(int'(byp_cnt) - by0 == by, {req, " forwarded operands"}, int'(byp_cnt) - by0, by);
      chk(holds - h0 == h, {req, " hold cycles"}, holds - h0, h);
   endtask

   task automatic t_reset();
      chk(x1_vld == 0, "R12 x1_vld", x1_vld, 0);
      chk(dec_hold == 0, "R12 dec_hold", dec_hold, 0);
      chk(rf_rd_en_a == 0 && rf_rd_en_b == 0, "R12 read enables", rf_rd_en_a | rf_rd_en_b, 0);
      chk(rf_rd_cnt == 0 && byp_cnt == 0, "R12 counters", rf_rd_cnt + byp_cnt, 0);
   endtask

   task automatic t_indep();   // R1 R2
      open_win();
      issue("R1 indep", 1, 1, 1, 2, 1, 3);
      close_win("R2 indep", 2, 0, 0);
   endtask

   task automatic t_gap_b();   // R6 R3
      open_win();
      issue("R6 prod", 1, 1, 1, 2, 1, 4);
      issue("R6 other", 1, 5, 1, 6, 1, 9);
      issue("R6 cons", 1, 8, 1, 4, 1, 7);
      close_win("R6 gap-one port B", 5, 1, 0);
   endtask

   task automatic t_back_b();  // R5
      open_win();
      issue("R5 prod", 1, 1, 1, 2, 1, 4);
      issue("R5 cons B", 1, 8, 1, 4, 1, 7);
      close_win("R5 back-to-back port B", 3, 1, 1);
   endtask

   task automatic t_back_a();  // R4 R5 R7
      open_win();
      issue("R4 prod", 1, 1, 1, 2, 1, 4);
      issue("R7 cons A", 1, 4, 1, 8, 1, 7);
      close_win("R4 back-to-back port A", 4, 0, 2);
   endtask

   task automatic t_gap_a();   // R4
      open_win();
      issue("R4 prod", 1, 5, 1, 6, 1, 4);
      issue("R4 other", 1, 1, 1, 2, 1, 9);
      issue("R4 cons A", 1, 4, 1, 8, 1, 7);
      close_win("R4 gap-one port A", 6, 0, 1);
   endtask

   task automatic t_zero();    // R9
      open_win();
      issue("R9 prod", 1, 1, 1, 2, 1, 4);
      issue("R9 r0 and invalid", 1, 0, 0, 4, 0, 0);
      issue("R9 no-dst prod", 1, 5, 1, 6, 0, 4);
      issue("R9 cons", 1, 8, 1, 4, 1, 7);
      close_win("R9 zero and invalid", 6, 0, 0);
   endtask

   task automatic t_young();   // R8
      open_win();
      issue("R8 older", 1, 1, 1, 2, 1, 4);
      issue("R8 younger", 1, 5, 1, 6, 1, 4);
      issue("R8 cons", 1, 8, 1, 4, 1, 7);
      close_win("R8 youngest producer", 5, 1, 1);
   endtask

   task automatic t_far();     // R7 via write-back, R11
      open_win();
      issue("R7 prod", 1, 1, 1, 2, 1, 4);
      issue("R7 other1", 1, 5, 1, 6, 1, 9);
      issue("R7 other2", 1, 5, 1, 6, 1, 10);
      issue("R7 cons", 1, 8, 1, 4, 1, 7);
      close_win("R11 gap-two port B", 8, 0, 0);
   endtask

   initial begin
      for (int i = 0; i < NREG; i++) arch[i] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      poke(1, 11); poke(2, 22); poke(4, 7); poke(5, 5); poke(6, 6); poke(8, 100);
      t_indep();
      t_gap_b();
      t_back_b();
      t_back_a();
      t_gap_a();
      t_zero();
      t_young();
      t_far();
      chk(q_rd == q_wr, "R1 instructions delivered", q_rd, q_wr);
      summary();
   end

endmodule